// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a 16-bit processor and picks its next value. Each instruction passes through two phases. In the fetch phase, a fetch strobe advances the PC by one. In the execute phase, an execute strobe may redirect the PC. A conditional branch (opcode `0000`) uses a three-bit mask to choose which of the negative, zero and positive flags to examine. If any examined flag is set, the PC is loaded from a dedicated offset adder. That adder adds the sign-extended low nine instruction bits to the PC, which already holds the incremented value. A register jump (opcode `1100`) loads the PC with a register value. The surrounding datapath reads that value from the register that instruction bits [8:6] name and drives it onto `reg_val`.

The controller is a two-state machine: `PH_FETCH` and `PH_EXEC`. Transition `T_FETCHED` goes from `PH_FETCH` to `PH_EXEC` when the fetch strobe is accepted. Transition `T_RETIRED` goes from `PH_EXEC` back to `PH_FETCH` when the execute strobe is accepted. Each state loops on itself while its strobe is low. The select output `pc_sel` shows which input of the next-PC multiplexer loads the PC in the current cycle: `0` increment, `1` offset adder, `2` register bus, `3` hold. `taken` is high in the cycle a control-flow redirect is applied.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is low, and after reset is released with no strobe, `pc_q` equals the parameter `RESET_PC` (default `16'h3000`), `pc_sel` is 3 (hold) and `taken` is 0. The machine starts in `PH_FETCH`.
- R2: In `PH_FETCH` with `fetch_stb` high, `pc_sel` is 0 and the PC becomes PC+1 at the next edge, wrapping from `16'hFFFF` to `16'h0000`.
- R3: In `PH_EXEC` with `exec_stb` high and `instr[15:12]=0000`, the branch is taken when `(instr[11:9] & {flag_n,flag_z,flag_p})` is non-zero. Bit 11 enables N, bit 10 enables Z and bit 9 enables P. When taken, `taken` is 1, `pc_sel` is 1 and the PC becomes PC plus sign-extended `instr[8:0]`.
- R4: An untaken branch leaves the PC unchanged, with `pc_sel` 3 and `taken` 0.
- R5: A branch with mask `111` is always taken when exactly one flag is set.
- R6: A branch with mask `000` is never taken, whatever the flags.
- R7: The offset covers -256..+255 from the incremented PC: offset `0x0FF` adds 255, `0x100` subtracts 256, and `0x1FF` subtracts 1.
- R8: In `PH_EXEC` with `exec_stb` high and `instr[15:12]=1100`, `pc_sel` is 2, `taken` is 1 and the PC becomes `reg_val` in full.
- R9: Any other opcode under an accepted execute strobe leaves the PC unchanged, with `pc_sel` 3 and `taken` 0. The machine still returns to `PH_FETCH`.
- R10: A strobe that arrives in the wrong phase has no effect on the PC, `pc_sel` or `taken`. This covers `exec_stb` in `PH_FETCH` and `fetch_stb` in `PH_EXEC`. When both strobes are high, only the one matching the current phase acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stb | input | 1 | Fetch strobe; advances the PC in `PH_FETCH` |
| exec_stb | input | 1 | Execute strobe; applies control flow in `PH_EXEC` |
| instr | input | 16 | Instruction register contents |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| reg_val | input | 16 | Register value taken from the bus for jumps |
| pc_q | output | 16 | Program counter |
| taken | output | 1 | High when a redirect is applied this cycle |
| pc_sel | output | 2 | Next-PC select: 0 inc, 1 offset adder, 2 bus, 3 hold |

## Verification
The full-mask assertion assumes the condition flags are one-hot. The flags always hold exactly one of negative, zero or positive, so the bench never drives none or several of them. The bench also changes `instr`, `reg_val` and the flags only between edges, and only together with the strobes. Every control-flow check is therefore made against a stable instruction in the phase the machine is known to be in. Strobes in the wrong phase are applied on purpose, to show that they are ignored.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [1:0] {
        SEL_INC  = 2'd0,
        SEL_ADD  = 2'd1,
        SEL_BUS  = 2'd2,
        SEL_HOLD = 2'd3
    } npc_sel_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } npc_phase_e;

    localparam logic [3:0] OP_BRANCH = 4'b0000;
    localparam logic [3:0] OP_JUMP   = 4'b1100;
    localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] mask,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic                 hit
);
    logic [NUM_FLAGS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign hit_vec[i] = mask[i] & flags[i];
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/npc_offset_add.sv
module npc_offset_add #(
    parameter int unsigned W     = 16,
    parameter int unsigned OFF_W = 9
) (
    input  logic [W-1:0]     base,
    input  logic [OFF_W-1:0] off,
    output logic [W-1:0]     sum
);
    localparam int unsigned EXT_W = W - OFF_W;

    logic [W-1:0] off_ext;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    assign sum     = base + off_ext;
endmodule

// File: rtl/npc_phase_ctrl.sv
module npc_phase_ctrl
    import npc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_stb,
    input  logic       exec_stb,
    input  logic [3:0] opcode,
    input  logic       cond_hit,
    output npc_phase_e phase,
    output npc_sel_e   sel,
    output logic       taken
);
    npc_phase_e state_q, state_d;

    // next-state: T_FETCHED and T_RETIRED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH: if (fetch_stb) state_d = PH_EXEC;
            PH_EXEC:  if (exec_stb)  state_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        sel   = SEL_HOLD;
        taken = 1'b0;
        unique case (state_q)
            PH_FETCH: begin
                if (fetch_stb) sel = SEL_INC;
            end
            PH_EXEC: begin
                if (exec_stb) begin
                    if (opcode == OP_BRANCH && cond_hit) begin
                        sel   = SEL_ADD;
                        taken = 1'b1;
                    end else if (opcode == OP_JUMP) begin
                        sel   = SEL_BUS;
                        taken = 1'b1;
                    end
                end
            end
        endcase
    end

    assign phase = state_q;

    AST_TAKEN_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sel == SEL_ADD || sel == SEL_BUS)); // R3
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FETCH && fetch_stb) |=> (state_q == PH_EXEC)); // R10
    AST_NO_REDIRECT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FETCH) |-> !taken); // R10
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import npc_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 16,
    parameter int unsigned         OFF_W    = 9,
    parameter logic [ADDR_W-1:0]   RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic              exec_stb,
    input  logic [15:0]       instr,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_p,
    input  logic [ADDR_W-1:0] reg_val,
    output logic [ADDR_W-1:0] pc_q,
    output logic              taken,
    output logic [1:0]        pc_sel
);
    localparam int unsigned OPC_LO  = 12;
    localparam int unsigned MASK_LO = 9;
    localparam int unsigned MASK_HI = MASK_LO + NUM_FLAGS - 1;

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] br_target;
    logic [3:0]        opcode;
    logic [NUM_FLAGS-1:0] br_mask;
    logic [NUM_FLAGS-1:0] flags;
    logic              cond_hit;
    npc_sel_e          sel;
    npc_phase_e        phase;

    assign opcode  = instr[OPC_LO+3:OPC_LO];
    assign br_mask = instr[MASK_HI:MASK_LO];
    assign flags   = {flag_n, flag_z, flag_p};
    assign pc_inc  = pc_q + ADDR_W'(1);

    npc_cond_eval u_cond (
        .mask  (br_mask),
        .flags (flags),
        .hit   (cond_hit)
    );

    npc_offset_add #(.W(ADDR_W), .OFF_W(OFF_W)) u_add (
        .base (pc_q),
        .off  (instr[OFF_W-1:0]),
        .sum  (br_target)
    );

    npc_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_stb (fetch_stb),
        .exec_stb  (exec_stb),
        .opcode    (opcode),
        .cond_hit  (cond_hit),
        .phase     (phase),
        .sel       (sel),
        .taken     (taken)
    );

    // three-input next-PC multiplexer plus hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            unique case (sel)
                SEL_INC:  pc_q <= pc_inc;
                SEL_ADD:  pc_q <= br_target;
                SEL_BUS:  pc_q <= reg_val;
                SEL_HOLD: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_sel = sel;

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_INC) |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HOLD) |=> $stable(pc_q)); // R4
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BUS) |=> (pc_q == $past(reg_val))); // R8
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && phase == PH_EXEC && opcode == OP_BRANCH &&
         br_mask == 3'b111 && $onehot(flags)) |-> taken); // R5
    AST_NULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BRANCH && br_mask == 3'b000) |-> !taken); // R6
endmodule

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_stb = 1'b0;
    logic        exec_stb = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b1;
    logic        flag_p = 1'b0;
    logic [15:0] reg_val = 16'h0000;
    logic [15:0] pc_q;
    logic        taken;
    logic [1:0]  pc_sel;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [1:0]  sel;
        logic        tk;
        logic [15:0] pc;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [15:0] mpc = 16'h3000;
    logic        mexec = 1'b0;

    always #2.5 clk = ~clk;

    nextpc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .exec_stb(exec_stb),
        .instr(instr), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .reg_val(reg_val), .pc_q(pc_q), .taken(taken), .pc_sel(pc_sel)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic step(input logic f, input logic e, input logic [15:0] ins,
                        input logic [2:0] fl, input logic [15:0] rv, input string tag);
        exp_t it;
        @(negedge clk);
        fetch_stb = f;
        exec_stb  = e;
        instr     = ins;
        {flag_n, flag_z, flag_p} = fl;
        reg_val   = rv;
        it.sel = 2'd3; it.tk = 1'b0; it.pc = mpc; it.tag = tag;
        if (f && !mexec) begin
            it.sel = 2'd0; it.pc = mpc + 16'd1; mexec = 1'b1;
        end else if (e && mexec) begin
            mexec = 1'b0;
            if (ins[15:12] == 4'b0000 && (ins[11:9] & fl) != 3'b000) begin
                it.sel = 2'd1; it.tk = 1'b1;
                it.pc = mpc + {{7{ins[8]}}, ins[8:0]};
            end else if (ins[15:12] == 4'b1100) begin
                it.sel = 2'd2; it.tk = 1'b1; it.pc = rv;
            end
        end
        mpc = it.pc;
        sb.push_back(it);
        @(posedge clk);
    endtask

    // monitor: pops expectations and compares against outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                chk(it.tag, "pc_sel", 32'(pc_sel), 32'(it.sel));
                chk(it.tag, "taken", 32'(taken), 32'(it.tk));
                @(posedge clk);
                #1;
                chk(it.tag, "pc", 32'(pc_q), 32'(it.pc));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset pc", 32'(pc_q), 32'h3000);
        chk("R1", "reset sel", 32'(pc_sel), 32'd3);
        chk("R1", "reset taken", 32'(taken), 32'd0);
        rst_n = 1'b1;
        step(0, 0, 16'h0000, 3'b010, 16'h0, "R1 idle after reset");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h0E05, 3'b010, 16'h0, "R5 mask111 z");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h0803, 3'b001, 16'h0, "R4 mask100 flag p untaken");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h04FF, 3'b010, 16'h0, "R7 offset +255");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h0300, 3'b001, 16'h0, "R7 offset -256");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h0001, 3'b100, 16'h0, "R6 mask000 flag n");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'h0E40, 3'b100, 16'h0, "R5 mask111 n");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch");
        step(0, 1, 16'hC080, 3'b010, 16'hFFFF, "R8 jump");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R2 fetch wrap");
        step(0, 1, 16'h1261, 3'b001, 16'h0, "R9 other opcode");
        step(0, 1, 16'hC080, 3'b010, 16'h1234, "R10 exec in fetch phase");
        step(1, 1, 16'hC080, 3'b010, 16'h1234, "R10 both strobes in fetch");
        step(1, 0, 16'h0000, 3'b010, 16'h0, "R10 fetch in exec phase");
        step(0, 1, 16'h09FF, 3'b100, 16'h0, "R3 R7 taken offset -1");
        step(1, 0, 16'h0000, 3'b100, 16'h0, "R2 fetch");
        step(0, 1, 16'h0401, 3'b001, 16'h0, "R3 mask010 flag p untaken");
        step(0, 0, 16'h0000, 3'b010, 16'h0, "R1 idle hold");
        @(negedge clk);
        fetch_stb = 1'b0;
        exec_stb  = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule